// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in a motor bridge. It does so by chopping the low-side switch that is conducting. While the low side is on, an external sense comparator reports when the winding current has climbed past its reference. The block then ends the conduction interval and runs a fixed off interval. During that interval the current recirculates through the upper half of the bridge. Once the interval ends, the block closes the low side again.

The off interval follows slow-decay practice and has three parts:
- a dead gap,
- a stretch with the upper switch in synchronous rectification,
- a second dead gap.

At the start of every conduction interval the comparator is blanked for a short window, so a recovery spike cannot end the interval early. A minimum conduction time is also enforced, whatever the comparator reports. An enable input removes drive from both switches at once. Every duration is a parameter counted in clock cycles. All pins are plain level controls; no data stream crosses the boundary, so there is no valid/ready handshake.

Parameters: `T_OFF` is the off monostable length and covers the lead gap plus rectification. `T_DEAD` is the gap length. `T_BLANK` is the blanking window. `T_MINON` is the minimum conduction time. The parameters must satisfy `T_OFF > T_DEAD >= 1` and `T_MINON >= 1`.

Top module: `cot_chopper`

## Requirements
- R1: While `rst_n` is low, `ls_on_o` and `hs_sr_o` are 0 and `phase_o` reads 0 (idle).
- R2: `phase_o` encodes idle=0, conduct=1, lead gap=2, rectify=3, trail gap=4. With enable held high, the phases cycle in the order 1, 2, 3, 4, 1.
- R3: When conduction ends, both switches stay off for `T_DEAD` cycles. The high-side rectification enable is then high for `T_OFF - T_DEAD` cycles.
- R4: After rectification, both switches stay off for another `T_DEAD` cycles before the low side turns on. The low side is therefore off for `T_OFF + T_DEAD` cycles per chop.
- R5: The comparator passes through a two-flop synchronizer. If the comparator is raised in conduction cycle j (counting the first conduction cycle as 0) and held, and j+2 lies beyond both the blanking window and `T_MINON - 1`, conduction lasts j+3 cycles.
- R6: A comparator assertion whose synchronized value falls wholly within the first `T_BLANK` conduction cycles has no effect. Conduction goes on until a later assertion.
- R7: Conduction never lasts fewer than `T_MINON` cycles. A synchronized assertion that lands after blanking but before the minimum is remembered, and it ends conduction after exactly `T_MINON` cycles even if it has already gone away.
- R8: A low `en_i` drops `ls_on_o` and `hs_sr_o` in the same cycle without waiting for a clock edge. `phase_o` shows idle from the next edge on, and the block stays idle whatever the comparator does.
- R9: When `en_i` is high in idle, either after reset or after a disable, the block passes through `T_DEAD` cycles of trail gap and then begins conduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Bridge enable; low forces all switches off |
| cmp_raw_i | input | 1 | Asynchronous over-threshold flag from the sense comparator |
| ls_on_o | output | 1 | Low-side switch enable |
| hs_sr_o | output | 1 | High-side synchronous-rectification enable |
| phase_o | output | 3 | Current phase (encoding in R2) |

## Verification
The hardest case to reach from the pins is a comparator event that is remembered rather than acted on. This happens when the synchronized flag appears after blanking has closed but before the minimum conduction time is up, and then vanishes. To provoke it, the bench counts conduction cycles at the falling edge from the first cycle the low side is seen high. It places short comparator pulses at chosen offsets in that count, allowing for the two synchronizer cycles. Some pulses straddle the end of blanking and others sit wholly inside or after it. The bench then checks that conduction ends exactly at the minimum, or does not end at all until a later held assertion.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ON    = 3'd1,
    PH_LEAD  = 3'd2,
    PH_SR    = 3'd3,
    PH_TRAIL = 3'd4
  } phase_t;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] sh_r;
      always_ff @(posedge clk) begin
        if (!rst_n) sh_r <= '0;
        else        sh_r <= {sh_r[STAGES-2:0], d_i};
      end
      assign q_o = sh_r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/chop_span.sv
module chop_span #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_m1_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_m1_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/chop_ontrack.sv
module chop_ontrack #(
  parameter int W       = 16,
  parameter int T_BLANK = 100,
  parameter int T_MINON = 250
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         active_i,
  input  logic         cmp_i,
  output logic         trip_o,
  output logic [W-1:0] age_o
);
  localparam int AGE_CAP_I = (T_BLANK > T_MINON) ? T_BLANK : T_MINON;
  localparam logic [W-1:0] BLANK_C = W'(T_BLANK);
  localparam logic [W-1:0] MINON_C = W'(T_MINON - 1);
  localparam logic [W-1:0] CAP_C   = W'(AGE_CAP_I);

  logic [W-1:0] age_q;
  logic         pend_q;
  logic         open_w;
  logic         minok_w;

  assign open_w  = (age_q >= BLANK_C);
  assign minok_w = (age_q >= MINON_C);

  always_ff @(posedge clk) begin
    if (!rst_n)                        age_q <= '0;
    else if (start_i)                  age_q <= '0;
    else if (active_i && age_q != CAP_C) age_q <= age_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (start_i || !active_i)       pend_q <= 1'b0;
    else if (open_w && cmp_i)            pend_q <= 1'b1;
  end

  assign trip_o = active_i && minok_w && (pend_q || (open_w && cmp_i));
  assign age_o  = age_q;
endmodule

// File: rtl/cot_chopper.sv
module cot_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int T_OFF   = 1300,
  parameter int T_DEAD  = 100,
  parameter int T_BLANK = 100,
  parameter int T_MINON = 250,
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       cmp_raw_i,
  output logic       ls_on_o,
  output logic       hs_sr_o,
  output logic [2:0] phase_o
);
  localparam logic [CNT_W-1:0] LEN_DEAD = CNT_W'(T_DEAD - 1);
  localparam logic [CNT_W-1:0] LEN_SR   = CNT_W'(T_OFF - T_DEAD - 1);
  localparam logic [CNT_W-1:0] MINON_M1 = CNT_W'(T_MINON - 1);

  phase_t           ph_q, ph_n;
  logic             cmp_s;
  logic             span_done;
  logic             span_load;
  logic [CNT_W-1:0] span_len;
  logic             trip;
  logic             on_start;
  logic [CNT_W-1:0] on_age;

  chop_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_s)
  );

  chop_span #(.W(CNT_W)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (span_load),
    .len_m1_i (span_len),
    .done_o   (span_done)
  );

  chop_ontrack #(.W(CNT_W), .T_BLANK(T_BLANK), .T_MINON(T_MINON)) u_on (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (on_start),
    .active_i (ph_q == PH_ON),
    .cmp_i    (cmp_s),
    .trip_o   (trip),
    .age_o    (on_age)
  );

  always_comb begin
    ph_n = ph_q;
    if (!en_i) begin
      ph_n = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:  ph_n = PH_TRAIL;
        PH_ON:    if (trip)      ph_n = PH_LEAD;
        PH_LEAD:  if (span_done) ph_n = PH_SR;
        PH_SR:    if (span_done) ph_n = PH_TRAIL;
        PH_TRAIL: if (span_done) ph_n = PH_ON;
        default:  ph_n = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (ph_n)
      PH_LEAD, PH_TRAIL: span_len = LEN_DEAD;
      PH_SR:             span_len = LEN_SR;
      default:           span_len = '0;
    endcase
  end

  assign span_load = (ph_n != ph_q);
  assign on_start  = (ph_n == PH_ON) && (ph_q != PH_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_n;
  end

  assign ls_on_o = en_i && (ph_q == PH_ON);
  assign hs_sr_o = en_i && (ph_q == PH_SR);
  assign phase_o = ph_q;

  a_r2_lead_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LEAD) |=> (ph_q == PH_LEAD || ph_q == PH_SR || ph_q == PH_IDLE));

  a_r3_sr_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_sr_o) |-> ($past(ph_q) == PH_LEAD));

  a_r4_on_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on_o) |-> ($past(ph_q) == PH_TRAIL));

  a_r7_minon: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ON && en_i && on_age < MINON_M1) |=> (ph_q == PH_ON));

  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (ph_q == PH_IDLE));
endmodule

// File: tb/sim_cot_chopper.sv
module sim_cot_chopper;
  localparam int TD = 3;
  localparam int TO = 12;
  localparam int TB = 4;
  localparam int TM = 8;
  localparam int NV = 6;
  // columns: pulse start, pulse length, held-trip start, expected conduction length
  localparam int VT [NV][4] = '{
    '{0, 0,  6,  9},
    '{0, 2, 14, 17},
    '{1, 3, 40,  8},
    '{3, 1, 40,  8},
    '{0, 0, 20, 23},
    '{1, 1, 10, 13}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cmp = 1'b0;
  logic       ls, hs;
  logic [2:0] ph;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cot_chopper #(.CNT_W(8), .T_OFF(TO), .T_DEAD(TD), .T_BLANK(TB), .T_MINON(TM)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .cmp_raw_i (cmp),
    .ls_on_o   (ls),
    .hs_sr_o   (hs),
    .phase_o   (ph)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    @(negedge clk);
    while (!ls && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ls in reset", int'(ls), 0);
    chk("R1 hs in reset", int'(hs), 0);
    chk("R1 phase in reset", int'(ph), 0);
    rst_n = 1'b1;
    count_low(n);
    chk("R9 gap after reset", n, TD);

    for (int v = 0; v < NV; v++) begin
      int age, onlen, lows, hsf, hsc, bad;
      string tag;
      tag = (v == 1 || v == 5) ? "R6 blanked spike" :
            (v == 2 || v == 3) ? "R7 remembered trip" : "R5 held trip";
      chk("R2 conduct code", int'(ph), 1);
      age = 0;
      onlen = 0;
      while (ls && onlen < 200) begin
        cmp = ((age >= VT[v][0]) && (age < VT[v][0] + VT[v][1])) || (age >= VT[v][2]);
        onlen++;
        age++;
        @(negedge clk);
      end
      cmp = 1'b0;
      chk(tag, onlen, VT[v][3]);
      lows = 0; hsf = -1; hsc = 0; bad = 0;
      while (!ls && lows < 200) begin
        if (hs) begin
          hsc++;
          if (hsf < 0) hsf = lows;
        end
        if (lows == 0 && ph != 3'd2) bad++;
        if (lows == TD && ph != 3'd3) bad++;
        if (lows == TO + TD - 1 && ph != 3'd4) bad++;
        lows++;
        @(negedge clk);
      end
      chk("R3 rectify start", hsf, TD);
      chk("R3 rectify length", hsc, TO - TD);
      chk("R4 low-side off span", lows, TO + TD);
      chk("R2 phase order", bad, 0);
    end

    // disable during conduction
    en = 1'b0;
    #1;
    chk("R8 ls drops at once", int'(ls), 0);
    chk("R8 hs low", int'(hs), 0);
    @(negedge clk);
    chk("R8 idle phase", int'(ph), 0);
    cmp = 1'b1;
    begin
      int act = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (ls || hs || ph != 3'd0) act++;
      end
      chk("R8 stays idle with comparator high", act, 0);
    end
    cmp = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    count_low(n);
    chk("R9 gap after re-enable", n, TD);

    // disable during rectification
    cmp = 1'b1;
    begin
      int g = 0;
      while (ls && g < 200) begin g++; @(negedge clk); end
      cmp = 1'b0;
      g = 0;
      while (!hs && g < 200) begin g++; @(negedge clk); end
    end
    chk("R3 rectify reached", int'(hs), 1);
    en = 1'b0;
    #1;
    chk("R8 hs drops at once", int'(hs), 0);
    @(negedge clk);
    chk("R8 idle after rectify", int'(ph), 0);
    en = 1'b1;
    count_low(n);
    chk("R9 gap after second re-enable", n, TD);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule